// File: doc/BRIEF.md
# Doorbell Interrupt Unit

The block holds, for every CPU in a cluster, a 32-bit register of pending doorbells and a 32-bit register of doorbell enables. Software raises a doorbell with a single global trigger write. The write data carries a doorbell index and a bitmap of the CPUs that should receive it. Each receiving CPU then has that index set in its pending register. The low eight doorbells carry inter-processor interrupts, and the upper sixteen carry message-signalled interrupts that a bridge delivers as the same trigger write.

For each CPU the unit drives two registered request lines into the interrupt controller, one for the IPI group and one for the MSI group. The local write port lets a CPU acknowledge doorbells. A pending bit is cleared when a 0 is written to it and kept when a 1 is written to it, so writing back the inverse of a snapshot removes exactly the bits in that snapshot. A registered read port returns the pending and enable registers of any CPU.

Top module: `dbell_unit`

## Requirements
- R1: Reset clears all pending and enable registers of every CPU, and drives every `ipi_irq` and `msi_irq` bit low.
- R2: A global write with valid high at offset 0x4 sets pending bit `gw_data[4:0]` in every CPU c whose map bit `gw_data[8+c]` is 1. The change is visible from the next clock edge, and CPUs outside the map are unchanged.
- R3: A trigger whose map field `gw_data[8+NCPU-1:8]` is all zero sets the bit only in the CPU named by `gw_src`.
- R4: A local write at offset 0x8 to CPU `lw_cpu` ANDs its pending register with `lw_data`: 0 bits clear and 1 bits keep. Writing 0 clears every pending doorbell of that CPU.
- R5: A local write at offset 0xC replaces the enable register of CPU `lw_cpu` with `lw_data`.
- R6: `ipi_irq[c]` is high exactly when some bit in 7..0 is set in both the pending and the enable register of CPU c. It follows a register change at the same clock edge that changes the register.
- R7: `msi_irq[c]` is high exactly when some bit in 31..16 is set in both registers of CPU c. Pending bits 15..8 can be set and read back but drive neither request line.
- R8: When a trigger and an acknowledge write hit the same pending bit in the same cycle, the bit ends up set.
- R9: Trigger data 0xF00 | (n+16) raises MSI n (pending bit n+16) in every CPU whose map bit is set in 0xF, which is all CPUs at the default count of four.
- R10: Global writes at offsets other than 0x4 and local writes at offsets other than 0x8 and 0xC change no register.
- R11: `rd_data` is registered. One edge after `rd_cpu`/`rd_addr` are presented, it holds the pending register for offset 0x8, the enable register for offset 0xC, and zero for any other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gw_valid | input | 1 | Global write strobe |
| gw_src | input | CPU_W | CPU issuing the global write |
| gw_addr | input | ADDR_W | Global write offset |
| gw_data | input | 32 | Trigger data: index in [4:0], CPU map from bit 8 |
| lw_valid | input | 1 | Local write strobe |
| lw_cpu | input | CPU_W | CPU whose registers the local write addresses |
| lw_addr | input | ADDR_W | Local write offset |
| lw_data | input | 32 | Local write data |
| rd_cpu | input | CPU_W | CPU selected for read |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 32 | Registered read data |
| ipi_irq | output | NCPU | Per-CPU IPI request |
| msi_irq | output | NCPU | Per-CPU MSI request |

## Verification
Every register change lands on the clock edge that takes the write, and both request lines are computed from the next-state values, so each request is due at the first edge after the write. The bench drives a write on a falling edge and removes it on the following falling edge, then compares the request lines there, half a cycle after the edge they depend on. Read data takes one more edge, so a read is presented on a falling edge and compared on the next falling edge. That read therefore shows the state left by all earlier writes.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned MAP_LSB = 8;
  localparam int unsigned IPI_LSB = 0;
  localparam int unsigned IPI_MSB = 7;
  localparam int unsigned MSI_LSB = 16;
  localparam int unsigned MSI_MSB = 31;
  localparam int unsigned OFS_TRIG  = 4;
  localparam int unsigned OFS_CAUSE = 8;
  localparam int unsigned OFS_MASK  = 12;
endpackage

// File: rtl/dbell_trig_dec.sv
module dbell_trig_dec
  import dbell_pkg::*;
#(
  parameter int unsigned NCPU   = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              valid,
  input  logic [CPU_W-1:0]  src,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  data,
  output logic [NCPU-1:0]   hit,
  output logic [REG_W-1:0]  set_vec
);
  logic [NCPU-1:0] map;
  logic            fire;
  logic            unused_bits;

  assign unused_bits = ^{data[REG_W-1:MAP_LSB+NCPU], data[MAP_LSB-1:IDX_W]};

  always_comb begin
    map     = data[MAP_LSB +: NCPU];
    fire    = valid && (addr == ADDR_W'(OFS_TRIG));
    hit     = '0;
    if (fire) begin
      // an empty target map falls back to the writer itself
      hit = (map == '0) ? (NCPU'(1) << src) : map;
    end
    set_vec = REG_W'(1) << data[IDX_W-1:0];
  end
endmodule

// File: rtl/dbell_cpu_bank.sv
module dbell_cpu_bank
  import dbell_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [REG_W-1:0]  set_vec,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  cause_q,
  output logic [REG_W-1:0]  mask_q,
  output logic              ipi_q,
  output logic              msi_q
);
  logic [REG_W-1:0] cause_n;
  logic [REG_W-1:0] mask_n;

  always_comb begin
    cause_n = cause_q;
    mask_n  = mask_q;
    if (wr_en && (wr_addr == ADDR_W'(OFS_CAUSE))) cause_n = cause_n & wr_data;
    if (wr_en && (wr_addr == ADDR_W'(OFS_MASK)))  mask_n  = wr_data;
    // setting is applied after the clear so a collision leaves the bit set
    if (set_en) cause_n = cause_n | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '0;
      ipi_q   <= 1'b0;
      msi_q   <= 1'b0;
    end else begin
      cause_q <= cause_n;
      mask_q  <= mask_n;
      ipi_q   <= |(cause_n[IPI_MSB:IPI_LSB] & mask_n[IPI_MSB:IPI_LSB]);
      msi_q   <= |(cause_n[MSI_MSB:MSI_LSB] & mask_n[MSI_MSB:MSI_LSB]);
    end
  end
endmodule

// File: rtl/dbell_rdmux.sv
module dbell_rdmux
  import dbell_pkg::*;
#(
  parameter int unsigned NCPU   = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCPU*REG_W-1:0] cause_flat,
  input  logic [NCPU*REG_W-1:0] mask_flat,
  input  logic [CPU_W-1:0]      rd_cpu,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [REG_W-1:0]      rd_data
);
  logic [REG_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (int'(rd_cpu) < NCPU) begin
      if (rd_addr == ADDR_W'(OFS_CAUSE)) sel = cause_flat[rd_cpu*REG_W +: REG_W];
      if (rd_addr == ADDR_W'(OFS_MASK))  sel = mask_flat[rd_cpu*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel;
  end
endmodule

// File: rtl/dbell_unit.sv
module dbell_unit
  import dbell_pkg::*;
#(
  parameter int unsigned NCPU   = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gw_valid,
  input  logic [CPU_W-1:0]  gw_src,
  input  logic [ADDR_W-1:0] gw_addr,
  input  logic [31:0]       gw_data,
  input  logic              lw_valid,
  input  logic [CPU_W-1:0]  lw_cpu,
  input  logic [ADDR_W-1:0] lw_addr,
  input  logic [31:0]       lw_data,
  input  logic [CPU_W-1:0]  rd_cpu,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   msi_irq
);
  logic [NCPU-1:0]       hit;
  logic [REG_W-1:0]      set_vec;
  logic [NCPU*REG_W-1:0] cause_flat;
  logic [NCPU*REG_W-1:0] mask_flat;

  dbell_trig_dec #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_dec (
    .valid   (gw_valid),
    .src     (gw_src),
    .addr    (gw_addr),
    .data    (gw_data),
    .hit     (hit),
    .set_vec (set_vec)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic sel_local;
    assign sel_local = lw_valid && (int'(lw_cpu) == c);

    dbell_cpu_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .set_en  (hit[c]),
      .set_vec (set_vec),
      .wr_en   (sel_local),
      .wr_addr (lw_addr),
      .wr_data (lw_data),
      .cause_q (cause_flat[c*REG_W +: REG_W]),
      .mask_q  (mask_flat[c*REG_W +: REG_W]),
      .ipi_q   (ipi_irq[c]),
      .msi_q   (msi_irq[c])
    );
  end

  dbell_rdmux #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .cause_flat (cause_flat),
    .mask_flat  (mask_flat),
    .rd_cpu     (rd_cpu),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/dbell_unit_chk.sv
module dbell_unit_chk
  import dbell_pkg::*;
#(
  parameter int unsigned NCPU   = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  gw_valid,
  input logic [CPU_W-1:0]      gw_src,
  input logic [ADDR_W-1:0]     gw_addr,
  input logic [31:0]           gw_data,
  input logic                  lw_valid,
  input logic [CPU_W-1:0]      lw_cpu,
  input logic [ADDR_W-1:0]     lw_addr,
  input logic [31:0]           lw_data,
  input logic [NCPU-1:0]       ipi_irq,
  input logic [NCPU-1:0]       msi_irq,
  input logic [NCPU*REG_W-1:0] mask_flat
);
  logic unused_chk;
  assign unused_chk = ^gw_src;

  // R1: the edge that samples reset leaves both request vectors low
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (ipi_irq == '0 && msi_irq == '0));

  // R6: with no write of any kind the request lines hold
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!gw_valid && !lw_valid) |=> ($stable(ipi_irq) && $stable(msi_irq)));

  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    logic mask_wr;
    logic cause_wr;
    logic trig_c;
    assign mask_wr  = lw_valid && (int'(lw_cpu) == c) && (lw_addr == ADDR_W'(OFS_MASK));
    assign cause_wr = lw_valid && (int'(lw_cpu) == c) && (lw_addr == ADDR_W'(OFS_CAUSE));
    assign trig_c   = gw_valid && (gw_addr == ADDR_W'(OFS_TRIG)) && gw_data[MAP_LSB + c];

    // R5: an all-zero enable write silences both lines of that CPU
    a_r5_mask_zero: assert property (@(posedge clk) disable iff (rst)
      (mask_wr && lw_data == '0) |=> (!ipi_irq[c] && !msi_irq[c]));

    // R4: clearing all pending bits with no trigger silences both lines
    a_r4_clear_all: assert property (@(posedge clk) disable iff (rst)
      (cause_wr && lw_data == '0 && !gw_valid) |=> (!ipi_irq[c] && !msi_irq[c]));

    // R2, R8: an enabled IPI trigger raises the line, even against a clear
    a_r2_trig_raises_ipi: assert property (@(posedge clk) disable iff (rst)
      (trig_c && gw_data[4:3] == 2'b00 && !mask_wr &&
       mask_flat[c*REG_W + int'(gw_data[IDX_W-1:0])]) |=> ipi_irq[c]);

    // R7, R9: an enabled MSI trigger raises the MSI line
    a_r7_trig_raises_msi: assert property (@(posedge clk) disable iff (rst)
      (trig_c && gw_data[4] && !mask_wr &&
       mask_flat[c*REG_W + int'(gw_data[IDX_W-1:0])]) |=> msi_irq[c]);
  end
endmodule

bind dbell_unit dbell_unit_chk #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .gw_valid  (gw_valid),
  .gw_src    (gw_src),
  .gw_addr   (gw_addr),
  .gw_data   (gw_data),
  .lw_valid  (lw_valid),
  .lw_cpu    (lw_cpu),
  .lw_addr   (lw_addr),
  .lw_data   (lw_data),
  .ipi_irq   (ipi_irq),
  .msi_irq   (msi_irq),
  .mask_flat (mask_flat)
);

// File: tb/sim_dbell_unit.sv
module sim_dbell_unit;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gw_valid = 1'b0;
  logic [1:0]  gw_src = '0;
  logic [3:0]  gw_addr = '0;
  logic [31:0] gw_data = '0;
  logic        lw_valid = 1'b0;
  logic [1:0]  lw_cpu = '0;
  logic [3:0]  lw_addr = '0;
  logic [31:0] lw_data = '0;
  logic [1:0]  rd_cpu = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  ipi_irq;
  logic [3:0]  msi_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [31:0] m_cause [NCPU];
  logic [31:0] m_mask  [NCPU];

  always #4 clk = ~clk;

  dbell_unit u0 (
    .clk(clk), .rst(rst),
    .gw_valid(gw_valid), .gw_src(gw_src), .gw_addr(gw_addr), .gw_data(gw_data),
    .lw_valid(lw_valid), .lw_cpu(lw_cpu), .lw_addr(lw_addr), .lw_data(lw_data),
    .rd_cpu(rd_cpu), .rd_addr(rd_addr), .rd_data(rd_data),
    .ipi_irq(ipi_irq), .msi_irq(msi_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] exp_ipi();
    logic [3:0] v;
    for (int c = 0; c < NCPU; c++) v[c] = |(m_cause[c][7:0] & m_mask[c][7:0]);
    return v;
  endfunction

  function automatic logic [3:0] exp_msi();
    logic [3:0] v;
    for (int c = 0; c < NCPU; c++) v[c] = |(m_cause[c][31:16] & m_mask[c][31:16]);
    return v;
  endfunction

  task automatic mdl_trig(input logic [1:0] src, input logic [3:0] a, input logic [31:0] d);
    logic [3:0] map;
    if (a != 4'h4) return;
    map = d[11:8];
    if (map == 0) map = 4'b1 << src;
    for (int c = 0; c < NCPU; c++) if (map[c]) m_cause[c][d[4:0]] = 1'b1;
  endtask

  task automatic mdl_local(input logic [1:0] cpu, input logic [3:0] a, input logic [31:0] d);
    if (a == 4'h8) m_cause[cpu] = m_cause[cpu] & d;
    if (a == 4'hC) m_mask[cpu] = d;
  endtask

  task automatic gwr(input logic [1:0] src, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    gw_valid = 1; gw_src = src; gw_addr = a; gw_data = d;
    @(negedge clk);
    gw_valid = 0;
    mdl_trig(src, a, d);
  endtask

  task automatic lwr(input logic [1:0] cpu, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    lw_valid = 1; lw_cpu = cpu; lw_addr = a; lw_data = d;
    @(negedge clk);
    lw_valid = 0;
    mdl_local(cpu, a, d);
  endtask

  task automatic rd(input logic [1:0] cpu, input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_cpu = cpu; rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic chk_irq(input string tag);
    chk({tag, " ipi_irq"}, {28'b0, ipi_irq}, {28'b0, exp_ipi()});
    chk({tag, " msi_irq"}, {28'b0, msi_irq}, {28'b0, exp_msi()});
  endtask

  task automatic chk_regs(input string tag);
    logic [31:0] v;
    for (int c = 0; c < NCPU; c++) begin
      rd(c[1:0], 4'h8, v); chk({tag, " pending"}, v, m_cause[c]);
      rd(c[1:0], 4'hC, v); chk({tag, " enable"}, v, m_mask[c]);
    end
  endtask

  task automatic t_reset();
    chk_irq("R1 after reset");
    chk_regs("R1 R11 after reset");
  endtask

  task automatic t_mask();
    lwr(0, 4'hC, 32'hFFFF_00FF);
    lwr(1, 4'hC, 32'hFFFF_FFFF);
    lwr(2, 4'hC, 32'h0000_00FF);
    lwr(3, 4'hC, 32'hFFFF_0000);
    chk_regs("R5 enable write");
    chk_irq("R5 no pending");
  endtask

  task automatic t_ipi();
    gwr(0, 4'h4, 32'h0000_0503);
    chk_irq("R2 R6 IPI to cpus 0,2");
    chk_regs("R2 map targets only");
  endtask

  task automatic t_self();
    gwr(3, 4'h4, 32'h0000_0005);
    chk_regs("R3 empty map to self");
    chk_irq("R3 self with IPI disabled");
  endtask

  task automatic t_msi();
    gwr(1, 4'h4, 32'h0000_0F00 | (2 + 16));
    chk_irq("R9 R7 MSI 2 to all");
    chk_regs("R9 bit 18 set");
  endtask

  task automatic t_ack();
    logic [31:0] snap;
    rd(0, 4'h8, snap);
    chk("R4 snapshot cpu0", snap, m_cause[0]);
    gwr(0, 4'h4, 32'h0000_0101);
    lwr(0, 4'h8, ~snap);
    chk_irq("R4 ack snapshot keeps new");
    chk_regs("R4 ack snapshot");
    lwr(2, 4'h8, 32'h0);
    chk_irq("R4 clear all cpu2");
    chk_regs("R4 clear all");
  endtask

  task automatic t_mid();
    lwr(1, 4'h8, 32'h0);
    gwr(1, 4'h4, 32'h0000_020A);
    chk_irq("R7 bit 10 drives no line");
    chk_regs("R7 bit 10 readable");
  endtask

  task automatic t_conflict();
    @(negedge clk);
    lw_valid = 1; lw_cpu = 1; lw_addr = 4'h8; lw_data = 32'h0;
    gw_valid = 1; gw_src = 0; gw_addr = 4'h4; gw_data = 32'h0000_020A;
    @(negedge clk);
    lw_valid = 0; gw_valid = 0;
    mdl_local(1, 4'h8, 32'h0);
    mdl_trig(0, 4'h4, 32'h0000_020A);
    chk_regs("R8 set beats clear");
    @(negedge clk);
    lw_valid = 1; lw_cpu = 1; lw_addr = 4'h8; lw_data = 32'h0;
    gw_valid = 1; gw_src = 0; gw_addr = 4'h4; gw_data = 32'h0000_0204;
    @(negedge clk);
    lw_valid = 0; gw_valid = 0;
    mdl_local(1, 4'h8, 32'h0);
    mdl_trig(0, 4'h4, 32'h0000_0204);
    chk_irq("R8 set beats clear irq");
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    gwr(0, 4'h8, 32'h0000_0F01);
    gwr(0, 4'hC, 32'h0000_0F11);
    lwr(0, 4'h4, 32'h0);
    lwr(3, 4'h0, 32'h0);
    chk_irq("R10 ignored offsets");
    chk_regs("R10 ignored offsets");
    rd(0, 4'h4, v); chk("R11 other offset reads zero", v, 32'h0);
  endtask

  task automatic t_masked();
    gwr(3, 4'h4, 32'h0000_0801);
    chk_irq("R6 masked IPI stays low");
    lwr(3, 4'hC, 32'hFFFF_0002);
    chk_irq("R6 enable raises line");
    lwr(3, 4'hC, 32'h0);
    chk_irq("R6 disable drops line");
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCPU; c++) begin m_cause[c] = '0; m_mask[c] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_mask();
    t_ipi();
    t_self();
    t_msi();
    t_ack();
    t_mid();
    t_conflict();
    t_ignore();
    t_masked();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule